// File: doc/BRIEF.md
# Blink and Heartbeat Duty Sequencer

This block picks the duty value that one PWM channel uses in each PWM period. It takes a start duty, a goal duty and two 16-bit timing words, tempo and span. It also takes an end-of-period strobe from the pulse generator. Its 16-bit output feeds the pulse generator's comparator.

The block has three modes:
- **Steady:** with blinking off, the output is the start duty.
- **Blink:** the output shows the start duty for tempo+1 periods, then the goal duty for span+1 periods, and repeats.
- **Heartbeat:** the output ramps between the two duties. It moves one step every tempo+1 periods. Each step is span+1 units. It runs from the start duty to the goal duty and back, and the direction follows from which duty is larger.

Writing the configuration, clearing the blink enable, or changing the heartbeat enable restarts the sequence at the start duty. The counters only advance on the end-of-period strobe.

Top module: `blink_duty_seq`

## Requirements
- R1: With `blink_en` low, `duty_o` equals `duty_start` in every cycle and follows it when it changes.
- R2: In blink mode (`blink_en`=1, `hbeat_en`=0), `duty_o` shows `duty_start` for `seq_tempo`+1 strobes. It then shows `duty_goal` for `seq_span`+1 strobes, and the pattern repeats.
- R3: In heartbeat mode (`blink_en`=1, `hbeat_en`=1), the level starts at `duty_start` and changes once every `seq_tempo`+1 strobes.
- R4: Each heartbeat step has size `seq_span`+1. The level moves toward `duty_goal` first, then back toward `duty_start`.
- R5: When `duty_goal` is below `duty_start`, the heartbeat level first decreases.
- R6: A step that would pass an endpoint lands exactly on that endpoint, and the next step moves away from it.
- R7: When `duty_start` equals `duty_goal`, the heartbeat level stays at that value.
- R8: Any of three events restarts the sequence in the next cycle, whether or not a strobe arrives in the same cycle. The events are a high `cfg_wr`, a low `blink_en`, or a change of `hbeat_en`. After a restart the output is `duty_start`, the dwell count is zero, and the ramp heads toward `duty_goal`.
- R9: Without a high `cyc_end`, the dwell count, blink phase and heartbeat level do not change.
- R10: The synchronous active-high reset clears the dwell count, selects the start phase and loads the ramp with `duty_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_end | input | 1 | One-cycle strobe at the end of each PWM period |
| blink_en | input | 1 | Enables blink or heartbeat sequencing |
| hbeat_en | input | 1 | Selects heartbeat ramp instead of two-level blink |
| cfg_wr | input | 1 | Pulses when any sequencing parameter is written; restarts the sequence |
| duty_start | input | 16 | Start duty, steady duty when not blinking |
| duty_goal | input | 16 | Goal duty for blink and heartbeat |
| seq_tempo | input | 16 | Blink: start-duty dwell minus one. Heartbeat: periods per step minus one |
| seq_span | input | 16 | Blink: goal-duty dwell minus one. Heartbeat: step size minus one |
| duty_o | output | 16 | Duty value for the current PWM period |

## Verification
A restart and a dwell-counter wrap can arrive in the same cycle. The restart must win, so the counter clears and the level reloads instead of stepping or changing phase. The bench provokes this by pulsing `cfg_wr` together with `cyc_end` while a heartbeat runs with a tempo of zero, so every strobe is also a wrap. A reference model advances on every clock edge and queues the expected output. After that cycle the output must be the start duty, and the following strobe must produce the first step from it.

// File: rtl/duty_seq_pkg.sv
package duty_seq_pkg;

    localparam int unsigned DUTY_W = 16;

    typedef enum logic [1:0] {
        MODE_STEADY = 2'd0,
        MODE_BLINK  = 2'd1,
        MODE_HEART  = 2'd2
    } seq_mode_e;

    typedef enum logic {
        PH_START = 1'b0,
        PH_GOAL  = 1'b1
    } blink_phase_e;

    function automatic seq_mode_e pick_mode(input logic blink, input logic heart);
        if (!blink)
            return MODE_STEADY;
        else if (heart)
            return MODE_HEART;
        else
            return MODE_BLINK;
    endfunction

endpackage

// File: rtl/duty_dwell_ctr.sv
module duty_dwell_ctr #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          wrap
);
    logic [CW-1:0] count_q;

    assign wrap = tick && (count_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            count_q <= '0;
        else if (tick)
            count_q <= wrap ? '0 : count_q + 1'b1;
    end

    a_r2_wrap_clear: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (count_q == '0));

    a_r9_count_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !clr) |=> (count_q == $past(count_q) + 1'b1));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (!tick && !clr) |=> $stable(count_q));

endmodule

// File: rtl/duty_ramp.sv
module duty_ramp #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          step_en,
    input  logic [DW-1:0] end_start,
    input  logic [DW-1:0] end_goal,
    input  logic [DW-1:0] step_m1,
    output logic [DW-1:0] level
);
    logic [DW-1:0] level_q;
    logic          to_goal_q;
    logic [DW-1:0] target;
    logic [DW:0]   inc;
    logic [DW:0]   sum;
    logic [DW-1:0] gap;
    logic [DW-1:0] nxt_level;
    logic          nxt_flip;

    assign target = to_goal_q ? end_goal : end_start;
    assign inc    = {1'b0, step_m1} + {{DW{1'b0}}, 1'b1};
    assign sum    = {1'b0, level_q} + inc;
    assign gap    = level_q - target;

    always_comb begin
        nxt_level = level_q;
        nxt_flip  = 1'b0;
        if (target >= level_q) begin
            if (sum >= {1'b0, target}) begin
                nxt_level = target;
                nxt_flip  = 1'b1;
            end else begin
                nxt_level = sum[DW-1:0];
            end
        end else begin
            if ({1'b0, gap} <= inc) begin
                nxt_level = target;
                nxt_flip  = 1'b1;
            end else begin
                nxt_level = level_q - inc[DW-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            level_q   <= end_start;
            to_goal_q <= 1'b1;
        end else if (step_en) begin
            level_q   <= nxt_level;
            to_goal_q <= nxt_flip ? !to_goal_q : to_goal_q;
        end
    end

    assign level = level_q;

    a_r8_load_start: assert property (@(posedge clk) disable iff (rst)
        load |=> ((level_q == $past(end_start)) && to_goal_q));

    a_r9_ramp_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !load) |=> ($stable(level_q) && $stable(to_goal_q)));

    a_r4_step_bound: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load) |=>
        ((({1'b0, level_q} >= {1'b0, $past(level_q)}) ?
          ({1'b0, level_q} - {1'b0, $past(level_q)}) :
          ({1'b0, $past(level_q)} - {1'b0, level_q}))
         <= ({1'b0, $past(step_m1)} + {{DW{1'b0}}, 1'b1})));

endmodule

// File: rtl/blink_duty_seq.sv
module blink_duty_seq
    import duty_seq_pkg::*;
#(
    parameter int unsigned DW = DUTY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cyc_end,
    input  logic          blink_en,
    input  logic          hbeat_en,
    input  logic          cfg_wr,
    input  logic [DW-1:0] duty_start,
    input  logic [DW-1:0] duty_goal,
    input  logic [DW-1:0] seq_tempo,
    input  logic [DW-1:0] seq_span,
    output logic [DW-1:0] duty_o
);
    seq_mode_e     mode;
    blink_phase_e  phase_q;
    logic          heart_q;
    logic          restart;
    logic [DW-1:0] dwell_limit;
    logic          wrap;
    logic          wrap_eff;
    logic [DW-1:0] ramp_level;

    assign mode    = pick_mode(blink_en, hbeat_en);
    assign restart = !blink_en || cfg_wr || (hbeat_en != heart_q);

    always_ff @(posedge clk) begin
        if (rst)
            heart_q <= 1'b0;
        else
            heart_q <= hbeat_en;
    end

    assign dwell_limit = (mode == MODE_BLINK && phase_q == PH_GOAL) ? seq_span : seq_tempo;

    duty_dwell_ctr #(.CW(DW)) u_dwell (
        .clk   (clk),
        .rst   (rst),
        .clr   (restart),
        .tick  (cyc_end && (mode != MODE_STEADY)),
        .limit (dwell_limit),
        .wrap  (wrap)
    );

    assign wrap_eff = wrap && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart)
            phase_q <= PH_START;
        else if (wrap_eff && mode == MODE_BLINK)
            phase_q <= (phase_q == PH_START) ? PH_GOAL : PH_START;
    end

    duty_ramp #(.DW(DW)) u_ramp (
        .clk       (clk),
        .rst       (rst),
        .load      (restart),
        .step_en   (wrap_eff && (mode == MODE_HEART)),
        .end_start (duty_start),
        .end_goal  (duty_goal),
        .step_m1   (seq_span),
        .level     (ramp_level)
    );

    always_comb begin
        unique case (mode)
            MODE_BLINK: duty_o = (phase_q == PH_GOAL) ? duty_goal : duty_start;
            MODE_HEART: duty_o = ramp_level;
            default:    duty_o = duty_start;
        endcase
    end

    a_r8_restart_phase: assert property (@(posedge clk) disable iff (rst)
        restart |=> (phase_q == PH_START));

    a_r9_phase_hold: assert property (@(posedge clk) disable iff (rst)
        (!cyc_end && !restart) |=> $stable(phase_q));

    a_r2_phase_turn: assert property (@(posedge clk) disable iff (rst)
        (wrap_eff && mode == MODE_BLINK) |=> (phase_q != $past(phase_q)));

endmodule

// File: tb/test_blink_duty_seq.sv
module test_blink_duty_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cyc_end = 1'b0;
    logic        blink_en = 1'b0;
    logic        hbeat_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] duty_start = 16'h7FFF;
    logic [15:0] duty_goal  = 16'h7FFF;
    logic [15:0] seq_tempo  = 16'h0;
    logic [15:0] seq_span   = 16'h0;
    logic [15:0] duty_o;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R10";
    bit    done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    // reference model state
    int m_cnt, m_lvl, m_tgt, m_inc, m_lim;
    bit m_phb, m_tog, m_hbq, m_rs;

    blink_duty_seq i_blink_duty_seq (
        .clk(clk), .rst(rst), .cyc_end(cyc_end), .blink_en(blink_en),
        .hbeat_en(hbeat_en), .cfg_wr(cfg_wr), .duty_start(duty_start),
        .duty_goal(duty_goal), .seq_tempo(seq_tempo), .seq_span(seq_span),
        .duty_o(duty_o)
    );

    always #4 clk = !clk;

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int model_out();
        if (!blink_en) return int'(duty_start);
        if (hbeat_en)  return m_lvl;
        return m_phb ? int'(duty_goal) : int'(duty_start);
    endfunction

    // scoreboard producer: model advances at every edge, queues expectation
    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_phb = 0; m_lvl = int'(duty_start); m_tog = 1; m_hbq = 0;
        end else begin
            m_rs  = !blink_en || cfg_wr || (hbeat_en != m_hbq);
            m_hbq = hbeat_en;
            if (m_rs) begin
                m_cnt = 0; m_phb = 0; m_lvl = int'(duty_start); m_tog = 1;
            end else if (cyc_end) begin
                m_lim = (!hbeat_en && m_phb) ? int'(seq_span) : int'(seq_tempo);
                if (m_cnt >= m_lim) begin
                    m_cnt = 0;
                    if (hbeat_en) begin
                        m_tgt = m_tog ? int'(duty_goal) : int'(duty_start);
                        m_inc = int'(seq_span) + 1;
                        if (m_tgt >= m_lvl) begin
                            if (m_lvl + m_inc >= m_tgt) begin m_lvl = m_tgt; m_tog = !m_tog; end
                            else m_lvl = m_lvl + m_inc;
                        end else begin
                            if (m_lvl - m_tgt <= m_inc) begin m_lvl = m_tgt; m_tog = !m_tog; end
                            else m_lvl = m_lvl - m_inc;
                        end
                    end else begin
                        m_phb = !m_phb;
                    end
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end
            exp_q.push_back(model_out());
            tag_q.push_back(cur_tag);
        end
    end

    // scoreboard consumer
    always @(posedge clk) begin
        #2;
        if (!rst && exp_q.size() > 0)
            check(int'(duty_o), exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic cycle(input logic ce);
        @(negedge clk);
        cyc_end = ce;
        cfg_wr  = 1'b0;
    endtask

    task automatic write_cfg(input logic [15:0] a, input logic [15:0] b,
                             input logic [15:0] x, input logic [15:0] y,
                             input logic blk, input logic hb, input logic ce);
        @(negedge clk);
        duty_start = a; duty_goal = b; seq_tempo = x; seq_span = y;
        blink_en = blk; hbeat_en = hb; cfg_wr = 1'b1; cyc_end = ce;
    endtask

    task automatic run(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            cycle(1'b1);
            for (int g = 0; g < gap; g++) cycle(1'b0);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cycle(1'b0);
        // R10: reset state shows the start duty
        cur_tag = "R10";
        check(int'(duty_o), 16'h7FFF, "R10");

        // R1: steady output follows the start duty
        cur_tag = "R1";
        run(3, 0);
        @(negedge clk); duty_start = 16'h1234;
        run(4, 1);
        check(int'(duty_o), 16'h1234, "R1");

        // R2: blink dwell counts, hand-checked sequence
        cur_tag = "R2";
        write_cfg(16'h1000, 16'h3000, 16'd1, 16'd0, 1'b1, 1'b0, 1'b0);
        cycle(1'b1); check(int'(duty_o), 16'h1000, "R2");
        cycle(1'b1); check(int'(duty_o), 16'h1000, "R2");
        cycle(1'b1); check(int'(duty_o), 16'h3000, "R2");
        cycle(1'b1); check(int'(duty_o), 16'h1000, "R2");
        write_cfg(16'h0400, 16'hF000, 16'd2, 16'd3, 1'b1, 1'b0, 1'b0);
        run(24, 0);

        // R9: sparse strobes, nothing moves between them
        cur_tag = "R9";
        run(12, 3);

        // R3/R4/R6: heartbeat ascending with clamp at the goal and at the start
        cur_tag = "R6";
        write_cfg(16'h0000, 16'h0250, 16'd0, 16'h00FF, 1'b1, 1'b1, 1'b0);
        cycle(1'b1); check(int'(duty_o), 16'h0000, "R3");
        cycle(1'b1); check(int'(duty_o), 16'h0100, "R4");
        cycle(1'b1); check(int'(duty_o), 16'h0200, "R4");
        cycle(1'b1); check(int'(duty_o), 16'h0250, "R6");
        cycle(1'b1); check(int'(duty_o), 16'h0150, "R6");
        cycle(1'b1); check(int'(duty_o), 16'h0050, "R6");
        cycle(1'b1); check(int'(duty_o), 16'h0000, "R6");
        cycle(1'b1); check(int'(duty_o), 16'h0100, "R6");
        cur_tag = "R3";
        write_cfg(16'h0100, 16'h0500, 16'd2, 16'h00FF, 1'b1, 1'b1, 1'b0);
        run(30, 1);

        // R5: descending heartbeat
        cur_tag = "R5";
        write_cfg(16'h0800, 16'h0200, 16'd1, 16'h01FF, 1'b1, 1'b1, 1'b0);
        cycle(1'b1); cycle(1'b1); cycle(1'b1);
        check(int'(duty_o), 16'h0600, "R5");
        run(20, 0);

        // R7: equal endpoints hold
        cur_tag = "R7";
        write_cfg(16'h4444, 16'h4444, 16'd0, 16'd5, 1'b1, 1'b1, 1'b0);
        run(10, 0);
        check(int'(duty_o), 16'h4444, "R7");

        // R8: restart together with a wrap, blink clear, heartbeat toggle
        cur_tag = "R8";
        write_cfg(16'h0100, 16'hFF00, 16'd0, 16'h000F, 1'b1, 1'b1, 1'b0);
        run(5, 0);
        write_cfg(16'h0100, 16'hFF00, 16'd0, 16'h000F, 1'b1, 1'b1, 1'b1);
        cycle(1'b1); check(int'(duty_o), 16'h0100, "R8");
        cycle(1'b1); check(int'(duty_o), 16'h0110, "R8");
        run(4, 0);
        @(negedge clk); hbeat_en = 1'b0; cyc_end = 1'b1;
        cycle(1'b0); check(int'(duty_o), 16'h0100, "R8");
        run(6, 0);
        @(negedge clk); blink_en = 1'b0; cyc_end = 1'b1;
        @(negedge clk); blink_en = 1'b1; cyc_end = 1'b0;
        run(6, 1);

        // R10: reset in the middle of a blink run
        cur_tag = "R10";
        @(negedge clk); rst = 1'b1; cyc_end = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0; cyc_end = 1'b0;
        check(int'(duty_o), 16'h0100, "R10");
        run(8, 0);

        cycle(1'b0); cycle(1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule